// File: doc/BRIEF.md
# Indexed-Colour Scan-Out Engine

This block turns an 8-bit indexed image held in on-chip memory into a 640x480, 60 Hz raster for an external HDMI/DVI transmitter. The memory image starts with a 256-entry colour table of 32-bit words and is followed directly by a 320x240 array of colour indices. The engine owns a read-only port to this memory, which returns data exactly one clock after an address is presented. Every frame it walks the index array without any processor involvement. It looks up each index in the colour table and sends the colour out twice horizontally, on two consecutive pixel slots. Each source row is sent twice vertically, on two consecutive output lines.

A clock divider produces a pixel clock enable, one clock in every `CLK_PER_PIX`. A horizontal and vertical slot counter advances on that enable and supplies sync, data-enable and the line number. A fetch state machine runs a fixed memory schedule of `CLK_PER_PIX*2` clocks per source pixel. The schedule is started early on each active line, so that the colour for a source pixel is ready exactly when its first output slot is emitted.

The fetch states are ST_WAIT, ST_IDX_REQ, ST_IDX_LATCH, ST_CLUT_REQ, ST_CLUT_LATCH and ST_SPACE. ST_WAIT moves to ST_IDX_REQ on the line-start strobe. ST_IDX_REQ moves to ST_IDX_LATCH, then to ST_CLUT_REQ, then to ST_CLUT_LATCH, one clock each. From ST_CLUT_LATCH the machine returns to ST_WAIT after the last source column. Otherwise it moves to ST_IDX_REQ when the schedule has no spare clocks, or to ST_SPACE when it has spare clocks. ST_SPACE counts out `CLK_PER_PIX*2-4` clocks and then moves to ST_IDX_REQ.

Top module: `pfb_display`

## Requirements
- R1: While `rst_n` is low, `de` is 0, `hsync_n` and `vsync_n` are 1, `rgb` is 0 and `pix_ce` is 0.
- R2: `pix_ce` is high on one clock in every `CLK_PER_PIX`, first on the second clock after reset is released. The video outputs change only at a clock edge where `pix_ce` is high, and each such edge emits the next pixel slot. Slot n (counted from 0 at the first such edge) has column h = n mod H_TOTAL and line v = (n div H_TOTAL) mod V_TOTAL.
- R3: Each line orders its columns as front porch (H_FP), sync (H_SYNC), back porch (H_BP) and then active (H_ACTIVE). `hsync_n` is 0 exactly on the sync columns.
- R4: Each frame orders its lines as front porch (V_FP), sync (V_SYNC), back porch (V_BP) and then active (V_ACTIVE). `vsync_n` is 0 exactly on the sync lines.
- R5: `de` is 1 exactly on slots whose column and line are both in the active part.
- R6: `rgb` is 0 on every slot where `de` is 0.
- R7: The colour table occupies word addresses 0 to 255, and the colour for index k is read from word address k. In that word red is bits [23:16], green is bits [15:8] and blue is bits [7:0], and these go to `rgb` in the same bit positions. Bits [31:24] have no effect on the output.
- R8: The source pixel at row r and column c reads word address 256 + r*(SRC_W/4) + c/4. Its index is byte c mod 4 of that word, with byte 0 in bits [7:0], so the low byte is the leftmost pixel.
- R9: Active output column x (counted from the first active column) shows source column x/2.
- R10: Active output line y (counted from the first active line) shows source row y/2.
- R11: Memory read data is used exactly one clock after the address is presented with `mem_rd` high. The image is read again every frame, so a change to memory contents between frames appears in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd | output | 1 | Read strobe for the memory port |
| mem_addr | output | MEM_AW | Word address for the memory port |
| mem_rdata | input | DATA_W | Read data, valid one clock after the address |
| pix_ce | output | 1 | Pixel clock enable for the transmitter |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high on visible slots |
| rgb | output | COLOR_W | Pixel colour, red in the top byte |

## Verification
A reduced raster of 16x8 active slots with short porches is swept through three whole frames, and every pixel slot is compared against values computed from the slot number. Each frame uses different memory contents, so a colour carried over from the previous frame shows up as a mismatch (R11). Index words hold a different value in every byte lane, so a swapped or shifted lane is caught (R8). Palette words carry non-zero upper bytes, so leakage of bits [31:24] is caught (R7). Odd columns and odd lines are checked separately, which separates broken pixel or line doubling (R9, R10) from plain address faults. The enable cadence is checked on every clock.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    // control bits of one output pixel slot
    typedef struct packed {
        logic de;
        logic hsync_n;
        logic vsync_n;
    } vid_ctl_t;

    localparam vid_ctl_t VID_CTL_IDLE = '{de: 1'b0, hsync_n: 1'b1, vsync_n: 1'b1};

    // memory schedule for one source pixel
    typedef enum logic [2:0] {
        ST_WAIT,
        ST_IDX_REQ,
        ST_IDX_LATCH,
        ST_CLUT_REQ,
        ST_CLUT_LATCH,
        ST_SPACE
    } fetch_state_e;

endpackage

// File: rtl/pfb_timing.sv
module pfb_timing
    import pfb_pkg::*;
#(
    parameter int CLK_PER_PIX = 2,
    parameter int H_ACTIVE    = 640,
    parameter int H_FP        = 16,
    parameter int H_SYNC      = 96,
    parameter int H_BP        = 48,
    parameter int V_ACTIVE    = 480,
    parameter int V_FP        = 10,
    parameter int V_SYNC      = 2,
    parameter int V_BP        = 33,
    parameter int ROW_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             pix_ce,
    output vid_ctl_t         ctl,
    output logic             line_go,
    output logic [ROW_W-1:0] line_row
);
    localparam int H_BLANK = H_FP + H_SYNC + H_BP;
    localparam int H_TOTAL = H_BLANK + H_ACTIVE;
    localparam int V_BLANK = V_FP + V_SYNC + V_BP;
    localparam int V_TOTAL = V_BLANK + V_ACTIVE;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);
    localparam int DW      = $clog2(CLK_PER_PIX);
    // the index request of source column 0 must sit four clocks
    // before the first active slot is emitted; the strobe is one earlier
    localparam int GO_CLK  = H_BLANK * CLK_PER_PIX - 5;
    localparam int GO_H    = GO_CLK / CLK_PER_PIX;
    localparam int GO_D    = GO_CLK % CLK_PER_PIX;

    logic [DW-1:0] div_q;
    logic [HW-1:0] h_q;
    logic [VW-1:0] v_q;
    logic [VW-1:0] v_rel;
    logic          h_last;
    logic          v_last;
    logic          v_act;

    assign pix_ce = (div_q == DW'(CLK_PER_PIX - 1));
    assign h_last = (h_q == HW'(H_TOTAL - 1));
    assign v_last = (v_q == VW'(V_TOTAL - 1));
    assign v_act  = (v_q >= VW'(V_BLANK));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            h_q   <= '0;
            v_q   <= '0;
        end else begin
            div_q <= pix_ce ? '0 : div_q + 1'b1;
            if (pix_ce) begin
                if (h_last) begin
                    h_q <= '0;
                    v_q <= v_last ? '0 : v_q + 1'b1;
                end else begin
                    h_q <= h_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        ctl.de      = (h_q >= HW'(H_BLANK)) && v_act;
        ctl.hsync_n = !((h_q >= HW'(H_FP)) && (h_q < HW'(H_FP + H_SYNC)));
        ctl.vsync_n = !((v_q >= VW'(V_FP)) && (v_q < VW'(V_FP + V_SYNC)));
    end

    assign line_go  = (h_q == HW'(GO_H)) && (div_q == DW'(GO_D)) && v_act;
    assign v_rel    = v_q - VW'(V_BLANK);
    assign line_row = ROW_W'(v_rel >> 1);

endmodule

// File: rtl/pfb_fetch.sv
module pfb_fetch
    import pfb_pkg::*;
#(
    parameter int CLK_PER_PIX = 2,
    parameter int SRC_W       = 320,
    parameter int SRC_H       = 240,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 8,
    parameter int COLOR_W     = 24,
    parameter int ROW_W       = 8,
    parameter int AW          = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_go,
    input  logic [ROW_W-1:0]   line_row,
    output logic               mem_rd,
    output logic [AW-1:0]      mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [COLOR_W-1:0] colour
);
    localparam int PPW     = DATA_W / IDX_W;
    localparam int LANE_W  = $clog2(PPW);
    localparam int WPR     = SRC_W / PPW;
    localparam int COL_W   = $clog2(SRC_W);
    localparam int FB_BASE = 2 ** IDX_W;
    localparam int GAP     = 2 * CLK_PER_PIX - 4;
    localparam int GAP_W   = (GAP > 1) ? $clog2(GAP) : 1;
    localparam int GAP_LD  = (GAP > 0) ? GAP - 1 : 0;

    fetch_state_e       state_q;
    fetch_state_e       state_d;
    logic [COL_W-1:0]   col_q;
    logic [ROW_W-1:0]   row_q;
    logic [DATA_W-1:0]  word_q;
    logic [COLOR_W-1:0] colour_q;
    logic [GAP_W-1:0]   gap_q;

    logic               last_col;
    logic               need_word;
    logic [LANE_W-1:0]  lane;
    logic [IDX_W-1:0]   pix_idx;
    logic [AW-1:0]      word_addr;

    assign last_col  = (col_q == COL_W'(SRC_W - 1));
    assign lane      = col_q[LANE_W-1:0];
    assign need_word = (lane == '0);
    assign pix_idx   = word_q[int'(lane) * IDX_W +: IDX_W];
    assign word_addr = AW'(FB_BASE) + AW'(row_q) * AW'(WPR) + AW'(col_q >> LANE_W);
    assign colour    = colour_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:       if (line_go) state_d = ST_IDX_REQ;
            ST_IDX_REQ:    state_d = ST_IDX_LATCH;
            ST_IDX_LATCH:  state_d = ST_CLUT_REQ;
            ST_CLUT_REQ:   state_d = ST_CLUT_LATCH;
            ST_CLUT_LATCH: begin
                if (last_col)      state_d = ST_WAIT;
                else if (GAP == 0) state_d = ST_IDX_REQ;
                else               state_d = ST_SPACE;
            end
            ST_SPACE:      if (gap_q == '0) state_d = ST_IDX_REQ;
            default:       state_d = ST_WAIT;
        endcase
    end

    // memory port outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        unique case (state_q)
            ST_IDX_REQ: begin
                mem_rd   = need_word;
                mem_addr = word_addr;
            end
            ST_CLUT_REQ: begin
                mem_rd   = 1'b1;
                mem_addr = AW'(pix_idx);
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q    <= '0;
            row_q    <= '0;
            word_q   <= '0;
            colour_q <= '0;
            gap_q    <= '0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (line_go) begin
                        col_q <= '0;
                        row_q <= line_row;
                    end
                end
                ST_IDX_LATCH: begin
                    if (need_word) word_q <= mem_rdata;
                end
                ST_CLUT_LATCH: begin
                    colour_q <= mem_rdata[COLOR_W-1:0];
                    col_q    <= col_q + 1'b1;
                    gap_q    <= GAP_W'(GAP_LD);
                end
                ST_SPACE: begin
                    gap_q <= gap_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pfb_pixout.sv
module pfb_pixout
    import pfb_pkg::*;
#(
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_ce,
    input  vid_ctl_t           ctl,
    input  logic [COLOR_W-1:0] colour,
    output vid_ctl_t           ctl_q,
    output logic [COLOR_W-1:0] rgb_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= VID_CTL_IDLE;
            rgb_q <= '0;
        end else if (pix_ce) begin
            ctl_q <= ctl;
            rgb_q <= ctl.de ? colour : '0;
        end
    end

endmodule

// File: rtl/pfb_display.sv
module pfb_display
    import pfb_pkg::*;
#(
    parameter int CLK_PER_PIX = 2,
    parameter int H_ACTIVE    = 640,
    parameter int H_FP        = 16,
    parameter int H_SYNC      = 96,
    parameter int H_BP        = 48,
    parameter int V_ACTIVE    = 480,
    parameter int V_FP        = 10,
    parameter int V_SYNC      = 2,
    parameter int V_BP        = 33,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 8,
    parameter int COLOR_W     = 24,
    localparam int SRC_W      = H_ACTIVE / 2,
    localparam int SRC_H      = V_ACTIVE / 2,
    localparam int MEM_WORDS  = 2 ** IDX_W + SRC_W * SRC_H / (DATA_W / IDX_W),
    localparam int MEM_AW     = $clog2(MEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               mem_rd,
    output logic [MEM_AW-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               pix_ce,
    output logic               hsync_n,
    output logic               vsync_n,
    output logic               de,
    output logic [COLOR_W-1:0] rgb
);
    localparam int ROW_W = (SRC_H > 1) ? $clog2(SRC_H) : 1;

    vid_ctl_t           ctl_now;
    vid_ctl_t           ctl_out;
    logic               line_go;
    logic [ROW_W-1:0]   line_row;
    logic [COLOR_W-1:0] colour;

    pfb_timing #(
        .CLK_PER_PIX (CLK_PER_PIX),
        .H_ACTIVE    (H_ACTIVE),
        .H_FP        (H_FP),
        .H_SYNC      (H_SYNC),
        .H_BP        (H_BP),
        .V_ACTIVE    (V_ACTIVE),
        .V_FP        (V_FP),
        .V_SYNC      (V_SYNC),
        .V_BP        (V_BP),
        .ROW_W       (ROW_W)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_ce   (pix_ce),
        .ctl      (ctl_now),
        .line_go  (line_go),
        .line_row (line_row)
    );

    pfb_fetch #(
        .CLK_PER_PIX (CLK_PER_PIX),
        .SRC_W       (SRC_W),
        .SRC_H       (SRC_H),
        .DATA_W      (DATA_W),
        .IDX_W       (IDX_W),
        .COLOR_W     (COLOR_W),
        .ROW_W       (ROW_W),
        .AW          (MEM_AW)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_go   (line_go),
        .line_row  (line_row),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .colour    (colour)
    );

    pfb_pixout #(
        .COLOR_W (COLOR_W)
    ) u_pixout (
        .clk    (clk),
        .rst_n  (rst_n),
        .pix_ce (pix_ce),
        .ctl    (ctl_now),
        .colour (colour),
        .ctl_q  (ctl_out),
        .rgb_q  (rgb)
    );

    assign de      = ctl_out.de;
    assign hsync_n = ctl_out.hsync_n;
    assign vsync_n = ctl_out.vsync_n;

endmodule

// File: rtl/pfb_display_chk.sv
module pfb_display_chk #(
    parameter int AW        = 15,
    parameter int MEM_WORDS = 19456,
    parameter int COLOR_W   = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_ce,
    input logic               hsync_n,
    input logic               vsync_n,
    input logic               de,
    input logic [COLOR_W-1:0] rgb,
    input logic               mem_rd,
    input logic [AW-1:0]      mem_addr
);
    // R2: enable never on two clocks in a row
    p_ce_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> !pix_ce);

    // R2: video outputs only move at an enable edge
    p_hold_between_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ce |=> $stable({de, hsync_n, vsync_n, rgb}));

    // R5: visible slots never coincide with a sync pulse
    p_de_outside_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync_n && vsync_n));

    // R6: blanked slots are black
    p_blank_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (rgb == '0));

    // R8: reads stay inside the memory image
    p_addr_in_image_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (int'(mem_addr) < MEM_WORDS));

endmodule

bind pfb_display pfb_display_chk #(
    .AW        (MEM_AW),
    .MEM_WORDS (MEM_WORDS),
    .COLOR_W   (COLOR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_ce   (pix_ce),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .de       (de),
    .rgb      (rgb),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr)
);

// File: tb/pfb_display_tb.sv
module pfb_display_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 2;
    localparam int HA    = 16;
    localparam int HFP   = 2;
    localparam int HS    = 3;
    localparam int HBP   = 3;
    localparam int VA    = 8;
    localparam int VFP   = 1;
    localparam int VS    = 2;
    localparam int VBP   = 2;
    localparam int HB    = HFP + HS + HBP;
    localparam int HT    = HB + HA;
    localparam int VB    = VFP + VS + VBP;
    localparam int VT    = VB + VA;
    localparam int SW    = HA / 2;
    localparam int SH    = VA / 2;
    localparam int WPR   = SW / 4;
    localparam int AW    = $clog2(256 + SW * SH / 4);
    localparam int FRAMES = 3;
    localparam int N_CLK = FRAMES * HT * VT * DIV + DIV;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          pix_ce;
    logic          hsync_n;
    logic          vsync_n;
    logic          de;
    logic [23:0]   rgb;

    int  salt = 0;
    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pfb_display #(
        .CLK_PER_PIX (DIV),
        .H_ACTIVE    (HA),
        .H_FP        (HFP),
        .H_SYNC      (HS),
        .H_BP        (HBP),
        .V_ACTIVE    (VA),
        .V_FP        (VFP),
        .V_SYNC      (VS),
        .V_BP        (VBP)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .pix_ce    (pix_ce),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n),
        .de        (de),
        .rgb       (rgb)
    );

    // memory image: colour table with junk top bytes, then index words
    function automatic logic [31:0] mem_word(int a, int s);
        logic [31:0] w;
        if (a < 256) begin
            w[31:24] = 8'(165 ^ a);
            w[23:16] = 8'(a * 3 + s * 17);
            w[15:8]  = 8'((a ^ 90) + s);
            w[7:0]   = 8'(255 - a - s);
        end else begin
            for (int j = 0; j < 4; j++)
                w[j*8 +: 8] = 8'((a - 256) * 29 + j * 71 + s * 13 + 7);
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_word(int'(mem_addr), salt);
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: idle values under reset
        chk("R1 de", 32'(de), 32'd0);
        chk("R1 hsync_n", 32'(hsync_n), 32'd1);
        chk("R1 vsync_n", 32'(vsync_n), 32'd1);
        chk("R1 rgb", 32'(rgb), 32'd0);
        chk("R1 pix_ce", 32'(pix_ce), 32'd0);
        rst_n = 1'b1;

        for (int i = 1; i < N_CLK; i++) begin
            @(negedge clk);
            // R2: enable cadence
            chk("R2 pix_ce", 32'(pix_ce), 32'((i % DIV) == DIV - 1));
            if (pix_ce) begin
                int p;
                p = i / DIV - 1;
                if (p < 0) begin
                    chk("R1 de after release", 32'(de), 32'd0);
                    chk("R1 rgb after release", 32'(rgb), 32'd0);
                end else begin
                    int h, v, f, col, row, wa;
                    logic e_de, e_hs, e_vs;
                    logic [31:0] w;
                    logic [7:0] idx;
                    logic [23:0] e_rgb;
                    string tag;
                    h = p % HT;
                    v = (p / HT) % VT;
                    f = p / (HT * VT);
                    if (h == 0 && v == 0) salt = f;
                    e_de = (h >= HB) && (v >= VB);
                    e_hs = !((h >= HFP) && (h < HFP + HS));
                    e_vs = !((v >= VFP) && (v < VFP + VS));
                    e_rgb = '0;
                    tag = "R6 blank rgb";
                    if (e_de) begin
                        col = (h - HB) / 2;
                        row = (v - VB) / 2;
                        wa  = 256 + row * WPR + col / 4;
                        w   = mem_word(wa, f);
                        idx = w[(col % 4) * 8 +: 8];
                        e_rgb = mem_word(int'(idx), f) >> 0;
                        if (f > 0)                tag = "R11 refetch rgb";
                        else if ((h - HB) % 2)    tag = "R9 hdouble rgb";
                        else if ((v - VB) % 2)    tag = "R10 vdouble rgb";
                        else if (col % 4)         tag = "R8 lane rgb";
                        else                      tag = "R7 lookup rgb";
                    end
                    chk("R5 de", 32'(de), 32'(e_de));
                    chk("R3 hsync_n", 32'(hsync_n), 32'(e_hs));
                    chk("R4 vsync_n", 32'(vsync_n), 32'(e_vs));
                    chk(tag, 32'(rgb), 32'(e_rgb));
                end
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule